// File: doc/BRIEF.md
# Segmentation-Aware Transmit Burst Admission

This block sits beside a transmit DMA engine and decides, for each descriptor, when the engine may start reading host memory and how many bytes each read burst may cover. It compares the free byte count of the transmit packet buffer against what the descriptor needs. In plain mode, a descriptor goes out as one burst, and only once the buffer can hold all of it. In segmentation-offload mode, one descriptor may be served by several smaller bursts. Each burst is made as long as the free space allows.

In segmentation mode, header logic further down the path puts a header in front of every segment's payload. A burst that starts new segments therefore uses more buffer space than its payload length. The block charges one header length for each segment start inside the burst. It also holds back a pad reserve that software programs; the block does not derive this reserve itself.

A first burst of a segmentation descriptor is allowed only if the buffer can take one whole segment with its header, or the rest of a segment that is already partly fetched. A byte counter tracks how far the current segment has been fetched, and this count carries over from one segmentation descriptor to the next. Grants are offered with a valid/ready handshake, and a one-cycle done pulse closes each descriptor.

Top module: `seg_tx_admit`

## Requirements
- R1: With the segmentation flag clear, no grant is offered while buf_free is below the descriptor length; once it is at least the length, exactly one grant equal to the whole length is offered.
- R2: With the segmentation flag set, a grant may be shorter than the descriptor, and the descriptor is then served by several grants whose lengths add up to its length.
- R3: In segmentation mode a grant of L bytes costs L plus hdr bytes for every byte position inside the burst where the segment offset (fill plus position, modulo mss) is zero. Each grant is the largest L, no larger than the remaining length, whose cost fits in the usable space.
- R4: Usable space in segmentation mode is buf_free minus the pad reserve, clamped to zero. While the pad is at least buf_free, no grant is offered.
- R5: The first grant of a segmentation descriptor needs usable space of at least mss plus hdr when the fill count is zero. When the fill count is nonzero, it needs at least mss minus the fill count. Later grants of the same descriptor only need a nonzero length.
- R6: The fill count advances by every accepted segmentation grant, modulo mss. It is kept across segmentation descriptors and cleared when a plain descriptor is accepted.
- R7: grant_valid stays high with grant_len unchanged until grant_ready is seen. It drops for at least one cycle after each accepted grant. desc_done pulses for exactly one cycle once the whole length has been granted. A zero-length descriptor completes with no grant.
- R8: Length, flag, mss, hdr and pad are taken when desc_valid and desc_ready are both high. Changes on those inputs before desc_done are ignored.
- R9: After reset, desc_ready is high and grant_valid and desc_done are low, and desc_ready and grant_valid are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_valid | input | 1 | New descriptor offered |
| desc_ready | output | 1 | Block idle, descriptor accepted this cycle if valid |
| desc_len | input | LEN_W | Descriptor data length in bytes |
| desc_seg | input | 1 | Segmentation-offload flag |
| desc_mss | input | MSS_W | Segment payload size in bytes (nonzero when flag set) |
| desc_hdr | input | HDR_W | Header bytes inserted per segment |
| desc_pad | input | FREE_W | Software pad reserve in bytes |
| buf_free | input | FREE_W | Free bytes in the transmit packet buffer |
| grant_valid | output | 1 | Burst grant offered |
| grant_ready | input | 1 | DMA engine takes the grant |
| grant_len | output | LEN_W | Bytes the burst may fetch |
| desc_done | output | 1 | One-cycle pulse at descriptor completion |

## Verification
The bench sets the free space one byte short of the first-segment threshold, both with a zero fill count and with a fill count left over from an earlier descriptor. A design that ignored the carried fill, or failed to clear it after a plain descriptor, would grant early or never grant at all. It sizes bursts where one more byte would pull in an extra header. Miscounted headers show up as a grant one segment too long or too short. It sets the pad above the free space, where an underflowing subtraction would produce a huge burst. It also holds a grant unaccepted while the free space and descriptor inputs change, which shows whether the offered length drifts or the held configuration is resampled.

// File: rtl/seg_tx_admit_pkg.sv
package seg_tx_admit_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_EVAL  = 3'd1,
    ST_OFFER = 3'd2,
    ST_WAIT  = 3'd3,
    ST_DONE  = 3'd4
  } adm_state_e;
endpackage

// File: rtl/seg_tx_burst_size.sv
// Combinational burst sizing and admission decision.
module seg_tx_burst_size #(
  parameter int FREE_W = 16,
  parameter int LEN_W  = 16,
  parameter int MSS_W  = 14,
  parameter int HDR_W  = 8
) (
  input  logic [FREE_W-1:0] free_i,
  input  logic [FREE_W-1:0] pad_i,
  input  logic [MSS_W-1:0]  mss_i,
  input  logic [HDR_W-1:0]  hdr_i,
  input  logic [MSS_W-1:0]  fill_i,
  input  logic [LEN_W-1:0]  rem_i,
  input  logic              seg_i,
  input  logic              first_i,
  output logic              ok_o,
  output logic [LEN_W-1:0]  len_o
);
  localparam int CW = ((LEN_W > FREE_W) ? LEN_W : FREE_W) + 2;

  logic [CW-1:0] free_e, pad_e, mss_e, hdr_e, fill_e, rem_e;
  logic [CW-1:0] usable, head, unit, unit_safe, span, k, r, tail, raw, fit;
  logic          seg_gate;

  always_comb begin
    free_e    = CW'(free_i);
    pad_e     = CW'(pad_i);
    mss_e     = CW'(mss_i);
    hdr_e     = CW'(hdr_i);
    fill_e    = CW'(fill_i);
    rem_e     = CW'(rem_i);
    usable    = (free_e > pad_e) ? (free_e - pad_e) : '0;
    head      = (fill_e == '0) ? '0 : (mss_e - fill_e);
    unit      = mss_e + hdr_e;
    unit_safe = (unit == '0) ? CW'(1) : unit;
    span      = '0;
    k         = '0;
    r         = '0;
    tail      = '0;
    if (usable <= head) begin
      raw = usable;
    end else begin
      span = usable - head;
      k    = span / unit_safe;
      r    = span % unit_safe;
      tail = (r > hdr_e) ? (r - hdr_e) : '0;
      raw  = head + (k * mss_e) + tail;
    end
    fit = (raw < rem_e) ? raw : rem_e;
    if (!first_i)            seg_gate = 1'b1;
    else if (fill_e == '0)   seg_gate = (usable >= unit);
    else                     seg_gate = (usable >= head);
    if (seg_i) begin
      ok_o  = seg_gate && (fit != '0);
      len_o = LEN_W'(fit);
    end else begin
      ok_o  = (free_e >= rem_e);
      len_o = rem_i;
    end
  end
endmodule

// File: rtl/seg_tx_fill_track.sv
// Partial-segment byte counter, wraps at the segment size.
module seg_tx_fill_track #(
  parameter int MSS_W = 14,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [MSS_W-1:0] mss_i,
  output logic [MSS_W-1:0] fill_o
);
  localparam int SW = ((LEN_W > MSS_W) ? LEN_W : MSS_W) + 1;

  logic [MSS_W-1:0] fill_q, fill_n, mss_safe;
  logic [SW-1:0]    sum;
  logic             fill_en;

  always_comb begin
    mss_safe = (mss_i == '0) ? MSS_W'(1) : mss_i;
    sum      = SW'(fill_q) + SW'(len_i);
    fill_en  = clr_i || adv_i;
    fill_n   = clr_i ? '0 : MSS_W'(sum % SW'(mss_safe));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fill_q <= '0;
    else if (fill_en) fill_q <= fill_n;
  end

  assign fill_o = fill_q;
endmodule

// File: rtl/seg_tx_admit.sv
module seg_tx_admit
  import seg_tx_admit_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int FREE_W = 16,
  parameter int MSS_W  = 14,
  parameter int HDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [LEN_W-1:0]  desc_len,
  input  logic              desc_seg,
  input  logic [MSS_W-1:0]  desc_mss,
  input  logic [HDR_W-1:0]  desc_hdr,
  input  logic [FREE_W-1:0] desc_pad,
  input  logic [FREE_W-1:0] buf_free,
  output logic              grant_valid,
  input  logic              grant_ready,
  output logic [LEN_W-1:0]  grant_len,
  output logic              desc_done
);
  adm_state_e        state_q, state_n;
  logic [FREE_W-1:0] free_q, pad_q;
  logic [LEN_W-1:0]  rem_q, glen_q, calc_len;
  logic [MSS_W-1:0]  mss_q, fill;
  logic [HDR_W-1:0]  hdr_q;
  logic              seg_q, first_q, calc_ok;
  logic              start, accept, load_len;

  seg_tx_burst_size #(
    .FREE_W(FREE_W), .LEN_W(LEN_W), .MSS_W(MSS_W), .HDR_W(HDR_W)
  ) u_size (
    .free_i (free_q),
    .pad_i  (pad_q),
    .mss_i  (mss_q),
    .hdr_i  (hdr_q),
    .fill_i (fill),
    .rem_i  (rem_q),
    .seg_i  (seg_q),
    .first_i(first_q),
    .ok_o   (calc_ok),
    .len_o  (calc_len)
  );

  seg_tx_fill_track #(.MSS_W(MSS_W), .LEN_W(LEN_W)) u_fill (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (start && !desc_seg),
    .adv_i (accept && seg_q),
    .len_i (glen_q),
    .mss_i (mss_q),
    .fill_o(fill)
  );

  always_comb begin
    start    = (state_q == ST_IDLE) && desc_valid;
    accept   = (state_q == ST_OFFER) && grant_ready;
    load_len = (state_q == ST_EVAL) && (rem_q != '0) && calc_ok;
    state_n  = state_q;
    unique case (state_q)
      ST_IDLE:  if (desc_valid) state_n = ST_EVAL;
      ST_EVAL: begin
        if (rem_q == '0)  state_n = ST_DONE;
        else if (calc_ok) state_n = ST_OFFER;
      end
      ST_OFFER: if (grant_ready) state_n = ST_WAIT;
      ST_WAIT:  state_n = ST_EVAL;
      ST_DONE:  state_n = ST_IDLE;
      default:  state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      free_q  <= '0;
    end else begin
      state_q <= state_n;
      free_q  <= buf_free;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= 1'b0;
      mss_q <= '0;
      hdr_q <= '0;
      pad_q <= '0;
    end else if (start) begin
      seg_q <= desc_seg;
      mss_q <= desc_mss;
      hdr_q <= desc_hdr;
      pad_q <= desc_pad;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q   <= '0;
      first_q <= 1'b0;
    end else if (start) begin
      rem_q   <= desc_len;
      first_q <= 1'b1;
    end else if (accept) begin
      rem_q   <= rem_q - glen_q;
      first_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        glen_q <= '0;
    else if (load_len) glen_q <= calc_len;
  end

  assign desc_ready  = (state_q == ST_IDLE);
  assign grant_valid = (state_q == ST_OFFER);
  assign grant_len   = glen_q;
  assign desc_done   = (state_q == ST_DONE);
endmodule

// File: rtl/seg_tx_admit_chk.sv
module seg_tx_admit_chk #(
  parameter int LEN_W  = 16,
  parameter int FREE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              desc_ready,
  input logic              grant_valid,
  input logic              grant_ready,
  input logic [LEN_W-1:0]  grant_len,
  input logic              desc_done,
  input logic              seg_q,
  input logic [LEN_W-1:0]  rem_q,
  input logic [FREE_W-1:0] free_q,
  input logic [FREE_W-1:0] pad_q
);
  AST_PLAIN_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_valid) && !seg_q |-> grant_len == rem_q); // R1
  AST_GRANT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (grant_len <= rem_q) && (grant_len != '0)); // R2
  AST_PAD_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_valid) && seg_q |-> $past(free_q) > $past(pad_q)); // R4
  AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid && !grant_ready |=> grant_valid && $stable(grant_len)); // R7
  AST_OFFER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid && grant_ready |=> !grant_valid); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    desc_done |=> !desc_done); // R7
  AST_IDLE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(desc_ready && grant_valid)); // R9
endmodule

bind seg_tx_admit seg_tx_admit_chk #(.LEN_W(LEN_W), .FREE_W(FREE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .desc_ready (desc_ready),
  .grant_valid(grant_valid),
  .grant_ready(grant_ready),
  .grant_len  (grant_len),
  .desc_done  (desc_done),
  .seg_q      (seg_q),
  .rem_q      (rem_q),
  .free_q     (free_q),
  .pad_q      (pad_q)
);

// File: tb/seg_tx_admit_tb_top.sv
`timescale 1ns/1ps
module seg_tx_admit_tb_top;
  localparam int LEN_W  = 16;
  localparam int FREE_W = 16;
  localparam int MSS_W  = 14;
  localparam int HDR_W  = 8;

  logic              clk, rst_n;
  logic              desc_valid, desc_ready, desc_seg;
  logic [LEN_W-1:0]  desc_len, grant_len;
  logic [MSS_W-1:0]  desc_mss;
  logic [HDR_W-1:0]  desc_hdr;
  logic [FREE_W-1:0] desc_pad, buf_free;
  logic              grant_valid, grant_ready, desc_done;

  int  n_checks = 0;
  int  n_errs   = 0;
  int  mfill    = 0;
  bit  finished = 0;

  seg_tx_admit #(.LEN_W(LEN_W), .FREE_W(FREE_W), .MSS_W(MSS_W), .HDR_W(HDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_len(desc_len), .desc_seg(desc_seg), .desc_mss(desc_mss), .desc_hdr(desc_hdr),
    .desc_pad(desc_pad), .buf_free(buf_free), .grant_valid(grant_valid),
    .grant_ready(grant_ready), .grant_len(grant_len), .desc_done(desc_done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Largest burst whose payload plus inserted headers fits the usable space.
  function automatic int model_len(int usable, int fill, int mss, int hdr, int rem);
    int l = 0, cost = 0, f = fill, extra;
    while (l < rem) begin
      extra = (f == 0) ? hdr + 1 : 1;
      if (cost + extra > usable) break;
      cost += extra;
      l++;
      f = (f + 1) % mss;
    end
    return l;
  endfunction

  task automatic give_desc(int len, bit seg, int mss, int hdr, int pad);
    @(negedge clk);
    while (!desc_ready) @(negedge clk);
    desc_len   = LEN_W'(len);
    desc_seg   = seg;
    desc_mss   = MSS_W'(mss);
    desc_hdr   = HDR_W'(hdr);
    desc_pad   = FREE_W'(pad);
    desc_valid = 1'b1;
    @(negedge clk);
    desc_valid = 1'b0;
  endtask

  task automatic wait_grant(int maxc, output bit got, output int len);
    got = 0;
    len = 0;
    for (int i = 0; i < maxc; i++) begin
      if (grant_valid) begin
        got = 1;
        len = int'(grant_len);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic take();
    grant_ready = 1'b1;
    @(negedge clk);
    grant_ready = 1'b0;
  endtask

  task automatic no_grant(int n, string req);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      if (grant_valid) seen = 1;
      @(negedge clk);
    end
    chk(!seen, req, int'(seen), 0);
  endtask

  task automatic wait_done(string req);
    bit seen = 0;
    for (int i = 0; i < 12; i++) begin
      if (desc_done) begin
        seen = 1;
        break;
      end
      @(negedge clk);
    end
    chk(seen, req, int'(seen), 1);
    if (seen) begin
      @(negedge clk);
      chk(!desc_done, req, int'(desc_done), 0);
    end
  endtask

  // Serve the rest of a segmentation descriptor at a fixed free level.
  task automatic run_rest(int free_v, int pad, int mss, int hdr, int rem, string req);
    bit got;
    int l, exp, u;
    buf_free = FREE_W'(free_v);
    while (rem > 0) begin
      wait_grant(20, got, l);
      u   = (free_v > pad) ? free_v - pad : 0;
      exp = model_len(u, mfill, mss, hdr, rem);
      chk(got && l == exp, req, l, exp);
      if (!got) break;
      take();
      rem  -= l;
      mfill = (mfill + l) % mss;
    end
    wait_done("R7");
  endtask

  task automatic t_reset();
    chk(desc_ready == 1'b1, "R9", int'(desc_ready), 1);
    chk(grant_valid == 1'b0, "R9", int'(grant_valid), 0);
    chk(desc_done == 1'b0, "R9", int'(desc_done), 0);
  endtask

  task automatic t_plain();
    bit got;
    int l;
    buf_free = FREE_W'(100);
    give_desc(200, 0, 0, 0, 0);
    no_grant(8, "R1");
    buf_free = FREE_W'(300);
    wait_grant(10, got, l);
    chk(got && l == 200, "R1", l, 200);
    take();
    mfill = 0;
    wait_done("R7");
  endtask

  task automatic t_seg_split();
    bit got;
    int l;
    buf_free = FREE_W'(250);
    give_desc(1000, 1, 100, 20, 0);
    wait_grant(10, got, l);
    chk(got && l == 200, "R3", l, 200);   // 200 + 2*20 fits 250, 201 needs 3 headers
    chk(l < 1000, "R2", l, 999);
    take();
    mfill = (mfill + l) % 100;
    run_rest(250, 0, 100, 20, 1000 - l, "R2");
  endtask

  task automatic t_pad();
    bit got;
    int l;
    buf_free = FREE_W'(250);
    give_desc(400, 1, 64, 14, 300);
    no_grant(8, "R4");
    buf_free = FREE_W'(420);
    wait_grant(10, got, l);
    chk(got && l == 92, "R4", l, 92);
    take();
    mfill = (mfill + l) % 64;
    run_rest(2000, 300, 64, 14, 400 - l, "R3");
  endtask

  task automatic t_admit();
    bit got;
    int l;
    // fill is 16 of 64 here: 48 bytes finish the open segment
    buf_free = FREE_W'(47);
    give_desc(100, 1, 64, 14, 0);
    no_grant(8, "R5");
    buf_free = FREE_W'(48);
    wait_grant(10, got, l);
    chk(got && l == 48, "R6", l, 48);
    take();
    mfill = 0;
    buf_free = FREE_W'(200);
    wait_grant(10, got, l);
    chk(got && l == 52, "R5", l, 52);
    take();
    mfill = 52;
    wait_done("R7");
    // plain descriptor clears the carried fill
    buf_free = FREE_W'(200);
    give_desc(10, 0, 0, 0, 0);
    wait_grant(10, got, l);
    chk(got && l == 10, "R1", l, 10);
    take();
    mfill = 0;
    wait_done("R7");
    buf_free = FREE_W'(119);
    give_desc(300, 1, 100, 20, 0);
    no_grant(8, "R6");
    buf_free = FREE_W'(120);
    wait_grant(10, got, l);
    chk(got && l == 100, "R5", l, 100);
    take();
    mfill = 0;
    run_rest(1000, 0, 100, 20, 200, "R3");
  endtask

  task automatic t_hold();
    bit got;
    int l;
    buf_free = FREE_W'(400);
    give_desc(500, 1, 100, 20, 10);
    wait_grant(10, got, l);
    chk(got && l == 310, "R3", l, 310);
    buf_free = FREE_W'(50);
    desc_mss = MSS_W'(7);
    desc_hdr = HDR_W'(0);
    desc_pad = FREE_W'(999);
    desc_len = LEN_W'(3);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(grant_valid && int'(grant_len) == 310, "R7", int'(grant_len), 310);
    end
    take();
    chk(!grant_valid, "R7", int'(grant_valid), 0);
    buf_free = FREE_W'(400);
    mfill = 10;
    wait_grant(10, got, l);
    chk(got && l == 190, "R8", l, 190);
    take();
    mfill = 0;
    wait_done("R7");
  endtask

  task automatic t_zero();
    bit saw_g = 0, saw_d = 0;
    buf_free = FREE_W'(0);
    give_desc(0, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) begin
      if (grant_valid) saw_g = 1;
      if (desc_done) saw_d = 1;
      @(negedge clk);
    end
    chk(!saw_g, "R7", int'(saw_g), 0);
    chk(saw_d, "R7", int'(saw_d), 1);
  endtask

  initial begin
    rst_n = 1'b0; desc_valid = 1'b0; desc_len = '0; desc_seg = 1'b0;
    desc_mss = '0; desc_hdr = '0; desc_pad = '0; buf_free = '0; grant_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_seg_split();
    t_pad();
    t_admit();
    t_hold();
    t_zero();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end
endmodule